// File: doc/BRIEF.md
# I2C Serial Memory Target Engine

This block is the bus-facing engine of a small serial memory that answers as a target on an I2C bus. SCL and SDA arrive already synchronised to a faster system clock. The engine oversamples both lines and finds the START and STOP conditions. It shifts bytes in on rising SCL and shifts them out on falling SCL. It also checks the device-select byte and drives or samples the acknowledge bit on the ninth clock.

The engine holds the internal byte address. The device-select byte supplies the top address bits and a following byte supplies the low eight. Reads take data from a memory port whose read data must follow `mem_addr_o` in the same cycle. Reads can start at the current address, at an address just loaded, or continue through memory as long as the controller keeps acknowledging. Each written byte goes to a separate page-write controller as a one-cycle strobe with its address. A STOP that ends a write raises a commit pulse. While that controller reports a write cycle in progress, the engine answers no select byte, so the controller on the bus can poll until the cycle ends.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `wr_valid_o` and `wr_commit_o` are 0, and `mem_addr_o` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Clocked bits seen before any START are ignored: SDA is never pulled low for them.
- R3: A select byte is accepted only if its bits 7..4 are 1010. Its bit 0 chooses read (1) or write (0). Any other select byte gets no acknowledge, and the bus is then ignored until the next START or STOP.
- R4: For every byte the engine accepts as a receiver, it pulls SDA low from the falling SCL edge after the 8th bit until the falling edge after the 9th bit.
- R5: After a write select, the next byte sets the address to {a9, a8, byte}. Here a9 is select bit 2 and a8 is select bit 1, and select bit 3 is ignored. When ADDR_W is 9, bit 2 is ignored as well.
- R6: Every data byte after the address byte is output on a one-cycle `wr_valid_o` pulse with `wr_addr_o` equal to the current address. The address then advances by one.
- R7: A repeated START followed by a read select returns the byte at the address just loaded (selective read).
- R8: A read select with no address byte before it returns the byte at the current address. After a read, the current address points one past the last byte sent.
- R9: While the controller acknowledges read bytes, the engine sends the next byte. The address runs through all of memory and wraps from the last location to 0.
- R10: A NoACK from the controller ends the read. After the following STOP the engine is idle and SDA is released.
- R11: While `busy_i` is 1, no select byte is acknowledged.
- R12: A START or STOP in the middle of a byte aborts it and restarts bit counting. A new START can then be followed by a normal transfer. A STOP gives one `wr_commit_o` pulse only if a data byte was written since the last STOP.
- R13: The engine changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired value) |
| busy_i | input | 1 | Page-write controller is in its internal write cycle |
| mem_rdata_i | input | 8 | Read data for `mem_addr_o`, valid in the same cycle |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr_o | output | ADDR_W | Current internal byte address |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ADDR_W | Address of the strobed data byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse on a STOP that ends a write |

## Verification
The bench drives the select byte with several patterns: a wrong tag, a right tag while busy, a right tag with the ignored bit 3 set, and each combination of a9/a8. From the acknowledge and the loaded address it tells tag matching apart from address-bit extraction. It runs reads as selective, immediate and sequential across the top of memory. The expected bytes come from a computed fill pattern, so a wrong address, a missing post-increment or a missing wrap each gives a different byte. Finally it sends clock pulses before any START and truncated bytes cut by START or STOP. These show that only a START opens a transfer and that aborts restart bit counting.

// File: rtl/i2c_mem_pkg.sv
// Shared types and constants for the I2C memory target engine.
// Assumes nothing beyond a synthesizable 1800-2017 flow.
package i2c_mem_pkg;

    // Transfer phase of the engine.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // waiting for START
        PH_SEL   = 3'd1,   // receiving the device-select byte
        PH_ADDR  = 3'd2,   // receiving the low address byte
        PH_WDATA = 3'd3,   // receiving write data bytes
        PH_RDATA = 3'd4,   // sending read data bytes
        PH_SKIP  = 3'd5    // not addressed, wait for START or STOP
    } phase_e;

    localparam logic [3:0] SEL_TAG    = 4'b1010;
    localparam int         BYTE_BITS  = 8;
    localparam int         FRAME_BITS = BYTE_BITS + 1;
    localparam int         CNT_W      = $clog2(FRAME_BITS + 1);

endpackage

// File: rtl/i2c_line_monitor.sv
// Line monitor: keeps one-cycle-old copies of SCL and SDA and
// flags SCL edges and START/STOP conditions.
// Assumes both lines are synchronised to clk and that clk is several
// times faster than SCL, so every bus event spans at least one cycle.
module i2c_line_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Hold last-cycle line levels; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and conditions from the old and new levels.
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2c_byte_shifter.sv
// Byte shifter shared by receive and transmit.
// Receive: cap_en shifts the sampled SDA bit in at the LSB.
// Transmit: load_en parks a byte, adv_en moves the next bit to the MSB.
// Assumes the controller never asserts two enables in one cycle;
// load has priority if it does.
module i2c_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         adv_en,
    input  logic         load_en,
    input  logic         bit_i,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] data_o
);
    logic [W-1:0] sh_q;

    // Load, capture or advance the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_en) begin
            sh_q <= load_val;
        end else if (cap_en) begin
            sh_q <= {sh_q[W-2:0], bit_i};
        end else if (adv_en) begin
            sh_q <= {sh_q[W-2:0], 1'b0};
        end
    end

    assign data_o = sh_q;

endmodule

// File: rtl/i2c_addr_counter.sv
// Internal byte address counter.
// A load builds the address from the select-byte bits and the low byte.
// An increment wraps from the last location to 0.
// Assumes ADDR_W is 9 (a9 forced to 0) or 10 (a9 and a8 both used).
module i2c_addr_counter #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              inc_en,
    input  logic [1:0]        sel_bits,   // [1]=a9 candidate, [0]=a8
    input  logic [7:0]        low_byte,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - 8;

    logic [HI_W-1:0]   hi_bits;
    logic [ADDR_W-1:0] addr_q;

    // Select how many upper bits come from the select byte.
    generate
        if (HI_W >= 2) begin : g_two_hi
            assign hi_bits = sel_bits[HI_W-1:0];
        end else begin : g_one_hi
            assign hi_bits = sel_bits[0];
        end
    endgenerate

    // Load or advance the address; width gives natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_en) begin
            addr_q <= {hi_bits, low_byte};
        end else if (inc_en) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;

    // R9: the last location is followed by location 0.
    assert_addr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !load_en && (addr_q == {ADDR_W{1'b1}})) |=> (addr_q == '0));

endmodule

// File: rtl/i2c_mem_target.sv
// I2C memory target engine (top).
// Decodes the bus phases and handles the acknowledge bit. It drives the
// shifter and address counter, serves reads from a same-cycle memory port
// and strobes write bytes to a page-write controller.
// Assumes synchronised SCL/SDA, clk much faster than SCL, and that
// mem_rdata_i reflects mem_addr_o combinationally.
module i2c_mem_target #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              busy_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              wr_commit_o
);
    import i2c_mem_pkg::*;

    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] ACK_BIT   = CNT_W'(FRAME_BITS);

    logic scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] addr;

    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sda_oe_q;
    logic              rw_q;
    logic [1:0]        sel_hi_q;
    logic              host_ack_q;
    logic              wr_valid_q;
    logic [7:0]        wr_data_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic              wr_pend_q;
    logic              commit_q;

    logic bus_evt, active, rx_phase, sel_match;
    logic sh_cap, sh_adv, sh_load, a_load, a_inc;

    i2c_line_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    // Datapath strobes derived from phase, bit count and SCL edges.
    always_comb begin
        bus_evt   = start_det | stop_det;
        active    = (phase != PH_IDLE) && (phase != PH_SKIP);
        rx_phase  = (phase == PH_SEL) || (phase == PH_ADDR) || (phase == PH_WDATA);
        sel_match = (shreg[7:4] == SEL_TAG) && !busy_i;
        sh_cap    = !bus_evt && scl_rise && rx_phase && (bit_cnt < LAST_DATA);
        sh_adv    = !bus_evt && scl_fall && (phase == PH_RDATA)
                    && (bit_cnt != '0) && (bit_cnt < LAST_DATA);
        sh_load   = !bus_evt && scl_fall && (bit_cnt == ACK_BIT)
                    && (((phase == PH_SEL) && rw_q) || ((phase == PH_RDATA) && host_ack_q));
        a_load    = !bus_evt && scl_fall && (bit_cnt == LAST_DATA) && (phase == PH_ADDR);
        a_inc     = sh_load
                    || (!bus_evt && scl_fall && (bit_cnt == LAST_DATA) && (phase == PH_WDATA));
    end

    i2c_byte_shifter #(.W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (sh_cap),
        .adv_en   (sh_adv),
        .load_en  (sh_load),
        .bit_i    (sda_i),
        .load_val (mem_rdata_i),
        .data_o   (shreg)
    );

    i2c_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (a_load),
        .inc_en   (a_inc),
        .sel_bits (sel_hi_q),
        .low_byte (shreg),
        .addr_o   (addr)
    );

    // Phase sequencing, bit counting, SDA drive and write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            sda_oe_q   <= 1'b0;
            rw_q       <= 1'b0;
            sel_hi_q   <= '0;
            host_ack_q <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_data_q  <= '0;
            wr_addr_q  <= '0;
            wr_pend_q  <= 1'b0;
            commit_q   <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            commit_q   <= 1'b0;
            if (stop_det) begin
                phase     <= PH_IDLE;
                bit_cnt   <= '0;
                sda_oe_q  <= 1'b0;
                commit_q  <= wr_pend_q;
                wr_pend_q <= 1'b0;
            end else if (start_det) begin
                phase    <= PH_SEL;
                bit_cnt  <= '0;
                sda_oe_q <= 1'b0;
            end else if (active && scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                if ((phase == PH_RDATA) && (bit_cnt == LAST_DATA)) begin
                    host_ack_q <= !sda_i;
                end
            end else if (active && scl_fall) begin
                if (bit_cnt == LAST_DATA) begin
                    case (phase)
                        PH_SEL: begin
                            if (sel_match) begin
                                sda_oe_q <= 1'b1;
                                rw_q     <= shreg[0];
                                sel_hi_q <= shreg[2:1];
                            end else begin
                                sda_oe_q <= 1'b0;
                                phase    <= PH_SKIP;
                            end
                        end
                        PH_ADDR:  sda_oe_q <= 1'b1;
                        PH_WDATA: begin
                            sda_oe_q   <= 1'b1;
                            wr_valid_q <= 1'b1;
                            wr_data_q  <= shreg;
                            wr_addr_q  <= addr;
                            wr_pend_q  <= 1'b1;
                        end
                        default:  sda_oe_q <= 1'b0;
                    endcase
                end else if (bit_cnt == ACK_BIT) begin
                    bit_cnt  <= '0;
                    sda_oe_q <= 1'b0;
                    case (phase)
                        PH_SEL: begin
                            if (rw_q) begin
                                phase    <= PH_RDATA;
                                sda_oe_q <= !mem_rdata_i[7];
                            end else begin
                                phase <= PH_ADDR;
                            end
                        end
                        PH_ADDR: phase <= PH_WDATA;
                        PH_RDATA: begin
                            if (host_ack_q) begin
                                sda_oe_q <= !mem_rdata_i[7];
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                        default: ;
                    endcase
                end else if ((phase == PH_RDATA) && (bit_cnt != '0)) begin
                    sda_oe_q <= !shreg[6];
                end
            end
        end
    end

    assign sda_oe_o    = sda_oe_q;
    assign mem_addr_o  = addr;
    assign wr_valid_o  = wr_valid_q;
    assign wr_addr_o   = wr_addr_q;
    assign wr_data_o   = wr_data_q;
    assign wr_commit_o = commit_q;

    // R13: SDA is only ever pulled low in a cycle that saw SCL low.
    assert_sda_drive_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !$past(scl_i));

    // R11: a select byte ending while busy is never acknowledged.
    assert_busy_nack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && !bus_evt && (phase == PH_SEL) && (bit_cnt == LAST_DATA) && busy_i)
        |=> !sda_oe_o);

    // R10: a STOP releases SDA and returns to idle.
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_o && (phase == PH_IDLE)));

    // R12: a START restarts bit counting in the select phase.
    assert_start_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> ((bit_cnt == '0) && (phase == PH_SEL)));

    // R6: each write strobe lasts exactly one cycle.
    assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R4: a receiver acknowledge is held until the next SCL fall.
    assert_ack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o && rx_phase && !scl_fall && !bus_evt) |=> sda_oe_o);

endmodule

// File: tb/i2c_mem_target_tb_top.sv
// Directed bench for the I2C memory target engine: one task per scenario.
module i2c_mem_target_tb_top;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int Q      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl = 1'b1;
    logic              sda_m = 1'b1;
    logic              busy = 1'b0;
    logic              sda_bus;
    logic [7:0]        mem_rdata;
    logic              sda_oe;
    logic [ADDR_W-1:0] mem_addr;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              wr_commit;

    logic [7:0] mem [0:DEPTH-1];
    int tests = 0;
    int fails = 0;
    int wr_n = 0;
    int commit_n = 0;
    int r13_viol = 0;
    logic [ADDR_W-1:0] log_addr [0:15];
    logic [7:0]        log_data [0:15];
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    i2c_mem_target #(.ADDR_W(ADDR_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .busy_i      (busy),
        .mem_rdata_i (mem_rdata),
        .sda_oe_o    (sda_oe),
        .mem_addr_o  (mem_addr),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + (a >> 8) * 91 + 5) & 255);
    endfunction

    // Record write strobes, commits and SDA changes during SCL high (R13).
    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_n < 16) begin
                log_addr[wr_n] <= wr_addr;
                log_data[wr_n] <= wr_data;
            end
            if (wr_valid) wr_n <= wr_n + 1;
            if (wr_commit) commit_n <= commit_n + 1;
            if (scl && scl_prev && (sda_oe != oe_prev)) r13_viol <= r13_viol + 1;
        end
        scl_prev <= scl;
        oe_prev  <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;   wait_q(Q);
        scl = 1'b1;  wait_q(2 * Q);
        scl = 1'b0;  wait_q(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        b = sda_bus;  wait_q(Q);
        scl = 1'b0;   wait_q(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b0;   wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl = 1'b1;   wait_q(Q);
        sda_m = 1'b1; wait_q(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack_n);
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!host_ack);
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(wr_valid == 1'b0 && wr_commit == 1'b0, "R1 strobes", {wr_valid, wr_commit}, 0);
        check(mem_addr == '0, "R1 addr", mem_addr, 0);
    endtask

    task automatic t_no_start();
        logic a;
        scl = 1'b0; wait_q(Q);
        send_byte(8'hA0, a);
        check(a == 1'b1, "R2 ack before START", a, 1);
        check(sda_oe == 1'b0, "R2 sda released", sda_oe, 0);
    endtask

    task automatic t_bad_select();
        logic a;
        bus_start();
        send_byte(8'h50, a);
        check(a == 1'b1, "R3 wrong tag nack", a, 1);
        send_byte(8'hA0, a);
        check(a == 1'b1, "R3 ignored until START", a, 1);
        bus_stop();
    endtask

    task automatic t_write();
        logic a0, a1, a2, a3;
        int c0;
        c0 = commit_n;
        bus_start();
        send_byte(8'hAC, a0);   // bit3 set (ignored), a9=1, a8=0, write
        send_byte(8'h34, a1);
        send_byte(8'h11, a2);
        send_byte(8'h22, a3);
        check({a0, a1, a2, a3} == 4'b0000, "R4 acks on write", {a0, a1, a2, a3}, 0);
        check(mem_addr == 10'h236, "R5 loaded address then advanced", mem_addr, 10'h236);
        check(wr_n == 2, "R6 strobe count", wr_n, 2);
        check(log_addr[0] == 10'h234 && log_data[0] == 8'h11, "R6 first byte",
              {log_addr[0], log_data[0]}, {10'h234, 8'h11});
        check(log_addr[1] == 10'h235 && log_data[1] == 8'h22, "R6 second byte",
              {log_addr[1], log_data[1]}, {10'h235, 8'h22});
        bus_stop();
        wait_q(2);
        check(commit_n == c0 + 1, "R12 commit on STOP after write", commit_n, c0 + 1);
    endtask

    task automatic t_selective_read();
        logic a0, a1, a2;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA2, a0);   // a9=0, a8=1
        send_byte(8'h7F, a1);
        bus_start();
        send_byte(8'hA1, a2);
        recv_byte(1'b0, d);
        check({a0, a1, a2} == 3'b000, "R7 acks", {a0, a1, a2}, 0);
        check(d == pat(10'h17F), "R7 selective data", d, pat(10'h17F));
        bus_stop();
        check(sda_oe == 1'b0, "R10 released after NoACK+STOP", sda_oe, 0);
        check(mem_addr == 10'h180, "R8 address one past", mem_addr, 10'h180);
    endtask

    task automatic t_immediate_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, d);
        check(a == 1'b0, "R8 read select ack", a, 0);
        check(d == pat(10'h180), "R8 current address data", d, pat(10'h180));
        bus_stop();
    endtask

    task automatic t_seq_wrap();
        logic a0, a1, a2;
        logic [7:0] d;
        int exp_a [4] = '{10'h3FE, 10'h3FF, 0, 1};
        bus_start();
        send_byte(8'hA6, a0);   // a9=1, a8=1
        send_byte(8'hFE, a1);
        bus_start();
        send_byte(8'hA1, a2);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, d);
            check(d == pat(exp_a[k]), "R9 sequential/wrap data", d, pat(exp_a[k]));
        end
        bus_stop();
        check(mem_addr == 10'h002, "R9 wrapped address", mem_addr, 2);
    endtask

    task automatic t_busy();
        logic a;
        int c0;
        c0 = commit_n;
        busy = 1'b1;
        bus_start();
        send_byte(8'hA0, a);
        check(a == 1'b1, "R11 busy nack", a, 1);
        busy = 1'b0;
        bus_start();
        send_byte(8'hA0, a);
        check(a == 1'b0, "R11 ack after busy clears", a, 0);
        bus_stop();
        wait_q(2);
        check(commit_n == c0, "R12 no commit without data", commit_n, c0);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] d;
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        check(sda_oe == 1'b0 && mem_addr == 10'h002, "R12 STOP mid-byte",
              {sda_oe, mem_addr}, 2);
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, d);
        check(a == 1'b0, "R12 select after START mid-byte", a, 0);
        check(d == pat(2), "R12 data after abort", d, pat(2));
        bus_stop();
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_q(2);
        t_reset();
        t_no_start();
        t_bad_select();
        t_write();
        t_selective_read();
        t_immediate_read();
        t_seq_wrap();
        t_busy();
        t_abort();
        wait_q(2);
        check(r13_viol == 0, "R13 SDA stable while SCL high", r13_viol, 0);
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

endmodule